// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits in the command path of a four-bank, 16-bit synchronous DRAM controller. It keeps the burst length, the wrap order and the single-beat-write option that a mode-register command programs. For every accepted read or write column command, it produces the column address of each beat of the burst. The outputs are registered. Beat 0 shows the start column in the clock after the command, and each later beat follows one clock after the one before it.

The wrap order is sequential or interleaved. Sequential order adds the beat number to the low start bits, and interleaved order XORs the beat number into them. In both orders the bits above the burst block stay fixed. A full-page burst always steps sequentially through all 256 columns of the row and wraps around. It ends only on a burst stop or a new column command. A burst stop or a new column command cuts any burst short. For two clocks after a mode command, column commands are refused.

Top module: `burst_colseq`

## Requirements
- R1: After reset, beat_valid and burst_done are 0. The default mode is burst length 1, sequential order, with single-beat writes off.
- R2: mrs_op[2:0] selects the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. An accepted column command then emits exactly that many beats on consecutive clocks. burst_done is 1 only together with the last beat, and beat_valid is 0 in the clock after it.
- R3: When mrs_op[3]=0 (sequential), beat k has column = (start with its low log2(L) bits replaced by (start + k) mod L). L is the burst length.
- R4: When mrs_op[3]=1 (interleaved), beat k has column = (start with its low log2(L) bits replaced by start XOR k).
- R5: mrs_op[2:0]=111 selects full page. Beat k has column (start + k) mod 256 whatever the value of mrs_op[3]. The burst continues past 256 beats and burst_done never rises.
- R6: A stop_en sampled without col_en ends the burst: beat_valid and burst_done are 0 in the next clock.
- R7: An accepted col_en restarts the sequence from the new col_addr in the next clock, even in the middle of a burst.
- R8: When mrs_op[9]=1, a write command (col_wr=1) emits a single beat with burst_done set, and reads keep the programmed length. When mrs_op[9]=0, writes burst at the programmed length.
- R9: A mode command is ignored while a burst still has beats to come after the current clock.
- R10: A col_en in either of the two clocks after an accepted mode command is ignored and starts no beats.
- R11: A mode command with a reserved length code (100, 101 or 110) is ignored entirely, and the previous mode stays in force.
- R12: beat_bank holds the col_bank of the command for every beat of its burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mrs_en | input | 1 | Mode-register command strobe |
| mrs_op | input | 12 | Mode operand: [2:0] length, [3] order, [9] single-beat write |
| col_en | input | 1 | Read/write column command strobe |
| col_addr | input | 8 | Start column of the burst |
| col_bank | input | 2 | Bank of the column command |
| col_wr | input | 1 | 1 for a write command, 0 for a read |
| stop_en | input | 1 | Burst-stop command strobe |
| beat_col | output | 8 | Column address of the current beat |
| beat_bank | output | 2 | Bank of the current beat |
| beat_valid | output | 1 | A beat is present this clock |
| burst_done | output | 1 | The current beat is the last of a fixed-length burst |

## Verification
Random bursts use random start columns under each of the four fixed lengths in both wrap orders. With unaligned starts, the sequential result differs from the interleaved one, and this separates an adder from an XOR and exposes a wrong block mask. Directed cases follow:
- A full-page burst that starts at 0xFE shows the wrap across the row and the absence of burst_done past 256 beats.
- A stop in the middle of a burst, and a restart in the middle of a burst, show that the burst is cut off and that the sequence restarts from the new column.
- Write and read commands under both settings of the single-beat option show the single-beat writes of R8.
- A mode command during a burst, a reserved length code, and a column command in the lockout window each leave an effect at the ports that shows whether the command was refused.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int COL_W = 8;
  localparam int BANK_W = 2;
  localparam int OP_W = 12;

  typedef struct packed {
    logic [2:0] len_code;
    logic       inter;
    logic       swr;
  } bcs_mode_t;

  function automatic logic code_ok(input logic [2:0] c);
    return (c == 3'b000) || (c == 3'b001) || (c == 3'b010) ||
           (c == 3'b011) || (c == 3'b111);
  endfunction

  function automatic logic [COL_W-1:0] code_mask(input logic [2:0] c);
    logic [COL_W:0] one;
    one = {{COL_W{1'b0}}, 1'b1};
    if (c == 3'b111) return {COL_W{1'b1}};
    return COL_W'((one << c[1:0]) - 1'b1);
  endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
#(
  parameter int LOCK_CYC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mrs_en,
  input  logic [OP_W-1:0] mrs_op,
  input  logic            busy,
  output logic [COL_W-1:0] mask,
  output logic            full,
  output logic            inter,
  output logic            swr,
  output logic            locked
);
  localparam int LCK_W = $clog2(LOCK_CYC + 1);

  bcs_mode_t           mode_q;
  logic [LCK_W-1:0]    lock_q;
  logic                accept;

  assign accept = mrs_en && !busy && (lock_q == '0) && code_ok(mrs_op[2:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '{len_code: 3'b000, inter: 1'b0, swr: 1'b0};
      lock_q <= '0;
    end else if (accept) begin
      mode_q <= '{len_code: mrs_op[2:0], inter: mrs_op[3], swr: mrs_op[9]};
      lock_q <= LCK_W'(LOCK_CYC);
    end else if (lock_q != '0) begin
      lock_q <= lock_q - 1'b1;
    end
  end

  assign full   = (mode_q.len_code == 3'b111);
  assign mask   = code_mask(mode_q.len_code);
  assign inter  = mode_q.inter && !full;
  assign swr    = mode_q.swr;
  assign locked = (lock_q != '0);
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] start,
  input  logic [W-1:0] beat,
  input  logic [W-1:0] mask,
  input  logic         inter,
  output logic [W-1:0] col
);
  logic [W-1:0] low;

  always_comb begin
    if (inter) low = start ^ beat;
    else       low = start + beat;
    col = (start & ~mask) | (low & mask);
  end
endmodule

// File: rtl/bcs_beat_ctl.sv
module bcs_beat_ctl
  import bcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              col_go,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [BANK_W-1:0] col_bank,
  input  logic              col_wr,
  input  logic              stop_en,
  input  logic [COL_W-1:0]  mode_mask,
  input  logic              mode_full,
  input  logic              mode_inter,
  input  logic              mode_swr,
  output logic              busy,
  output logic [COL_W-1:0]  beat_col,
  output logic [BANK_W-1:0] beat_bank,
  output logic              beat_valid,
  output logic              burst_done
);
  logic              act_q, inter_q, full_q;
  logic [COL_W-1:0]  cnt_q, start_q, mask_q, nxt_col;
  logic [COL_W-1:0]  eff_mask;
  logic              eff_full, one_beat;

  bcs_addr_gen #(.W(COL_W)) u_gen (
    .start(start_q), .beat(cnt_q), .mask(mask_q), .inter(inter_q), .col(nxt_col)
  );

  always_comb begin
    one_beat = col_wr && mode_swr;
    eff_mask = one_beat ? '0 : mode_mask;
    eff_full = one_beat ? 1'b0 : mode_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= 1'b0;
      cnt_q      <= '0;
      start_q    <= '0;
      mask_q     <= '0;
      inter_q    <= 1'b0;
      full_q     <= 1'b0;
      beat_col   <= '0;
      beat_bank  <= '0;
      beat_valid <= 1'b0;
      burst_done <= 1'b0;
    end else if (col_go) begin
      start_q    <= col_addr;
      mask_q     <= eff_mask;
      inter_q    <= mode_inter;
      full_q     <= eff_full;
      cnt_q      <= COL_W'(1);
      beat_col   <= col_addr;
      beat_bank  <= col_bank;
      beat_valid <= 1'b1;
      burst_done <= (eff_mask == '0) && !eff_full;
      act_q      <= !((eff_mask == '0) && !eff_full);
    end else if (stop_en || !act_q) begin
      act_q      <= 1'b0;
      beat_valid <= 1'b0;
      burst_done <= 1'b0;
    end else begin
      cnt_q      <= cnt_q + 1'b1;
      beat_col   <= nxt_col;
      beat_valid <= 1'b1;
      burst_done <= (cnt_q == mask_q) && !full_q;
      act_q      <= !((cnt_q == mask_q) && !full_q);
    end
  end

  assign busy = act_q;
endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
  import bcs_pkg::*;
#(
  parameter int LOCK_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mrs_en,
  input  logic [OP_W-1:0]   mrs_op,
  input  logic              col_en,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [BANK_W-1:0] col_bank,
  input  logic              col_wr,
  input  logic              stop_en,
  output logic [COL_W-1:0]  beat_col,
  output logic [BANK_W-1:0] beat_bank,
  output logic              beat_valid,
  output logic              burst_done
);
  logic [COL_W-1:0] mode_mask;
  logic mode_full, mode_inter, mode_swr, locked, busy, col_go;

  assign col_go = col_en && !locked;

  bcs_mode_reg #(.LOCK_CYC(LOCK_CYC)) u_mode (
    .clk(clk), .rst(rst), .mrs_en(mrs_en), .mrs_op(mrs_op), .busy(busy),
    .mask(mode_mask), .full(mode_full), .inter(mode_inter), .swr(mode_swr),
    .locked(locked)
  );

  bcs_beat_ctl u_beat (
    .clk(clk), .rst(rst), .col_go(col_go), .col_addr(col_addr),
    .col_bank(col_bank), .col_wr(col_wr), .stop_en(stop_en),
    .mode_mask(mode_mask), .mode_full(mode_full), .mode_inter(mode_inter),
    .mode_swr(mode_swr), .busy(busy), .beat_col(beat_col),
    .beat_bank(beat_bank), .beat_valid(beat_valid), .burst_done(burst_done)
  );
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk (
  input logic       clk,
  input logic       rst,
  input logic       col_go,
  input logic [7:0] col_addr,
  input logic       col_wr,
  input logic       mode_swr,
  input logic       stop_en,
  input logic [7:0] beat_col,
  input logic [1:0] beat_bank,
  input logic       beat_valid,
  input logic       burst_done
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !beat_valid && !burst_done);
  // R2
  done_has_beat_chk: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> beat_valid);
  // R6
  stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_en && !col_go) |=> !beat_valid && !burst_done);
  // R7
  restart_col_chk: assert property (@(posedge clk) disable iff (rst)
    col_go |=> beat_valid && (beat_col == $past(col_addr)));
  // R8
  single_write_chk: assert property (@(posedge clk) disable iff (rst)
    (col_go && col_wr && mode_swr) |=> burst_done);
  // R12
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !col_go) |=> (!beat_valid || $stable(beat_bank)));
endmodule

bind burst_colseq bcs_chk u_chk (
  .clk(clk), .rst(rst), .col_go(col_go), .col_addr(col_addr),
  .col_wr(col_wr), .mode_swr(mode_swr), .stop_en(stop_en),
  .beat_col(beat_col), .beat_bank(beat_bank), .beat_valid(beat_valid),
  .burst_done(burst_done)
);

// File: tb/sim_burst_colseq.sv
`timescale 1ns/1ps
module sim_burst_colseq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mrs_en = 1'b0;
  logic [11:0] mrs_op = '0;
  logic col_en = 1'b0;
  logic [7:0] col_addr = '0;
  logic [1:0] col_bank = '0;
  logic col_wr = 1'b0;
  logic stop_en = 1'b0;
  logic [7:0] beat_col;
  logic [1:0] beat_bank;
  logic beat_valid, burst_done;
  int checks = 0;
  int errors = 0;
  logic [2:0] cur_code;
  logic cur_inter;

  always #5 clk = ~clk;

  burst_colseq u0 (.*);

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [7:0] k,
                                         input logic [2:0] code, input logic inter);
    logic [7:0] m, low;
    m = (code == 3'b111) ? 8'hFF : 8'((9'd1 << code[1:0]) - 9'd1);
    low = (inter && code != 3'b111) ? (s ^ k) : (s + k);
    return (s & ~m) | (low & m);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [11:0] op);
    @(negedge clk); mrs_en = 1'b1; mrs_op = op;
    @(negedge clk); mrs_en = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic start_cmd(input logic [7:0] s, input logic [1:0] b, input logic wr);
    @(negedge clk); col_en = 1'b1; col_addr = s; col_bank = b; col_wr = wr;
    @(negedge clk); col_en = 1'b0;
  endtask

  // starts at beat 0 sampled; checks n beats then idle
  task automatic run_burst(input string tag, input logic [7:0] s, input logic [1:0] b,
                           input logic wr, input int n, input logic [2:0] code,
                           input logic inter);
    start_cmd(s, b, wr);
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      chk({tag, " valid"}, beat_valid, 1);
      chk({tag, " col"}, beat_col, exp_col(s, 8'(k), code, inter));
      chk({tag, " R12 bank"}, beat_bank, b);
      chk({tag, " R2 done"}, burst_done, (k == n - 1) ? 1 : 0);
    end
    @(negedge clk);
    chk({tag, " R2 idle after"}, beat_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 valid after reset", beat_valid, 0);
    chk("R1 done after reset", burst_done, 0);
    run_burst("R1 default length 1", 8'h37, 2'd1, 1'b0, 1, 3'b000, 1'b0);

    // R2 R3 R4 random bursts
    for (int i = 0; i < 40; i++) begin
      cur_code = 3'($urandom_range(0, 3));
      cur_inter = 1'($urandom_range(0, 1));
      set_mode({8'h00, cur_inter, cur_code});
      run_burst(cur_inter ? "R4 interleave" : "R3 sequential",
                8'($urandom), 2'($urandom), 1'b0, 1 << cur_code, cur_code, cur_inter);
    end
    // R3 R4 directed, unaligned start in length 8
    set_mode(12'h003);
    run_burst("R3 seq len8 start 5D", 8'h5D, 2'd2, 1'b0, 8, 3'b011, 1'b0);
    set_mode(12'h00B);
    run_burst("R4 int len8 start 5D", 8'h5D, 2'd3, 1'b0, 8, 3'b011, 1'b1);

    // R5 full page, interleave bit set but ignored
    set_mode(12'h00F);
    start_cmd(8'hFE, 2'd0, 1'b0);
    for (int k = 0; k < 260; k++) begin
      if (k > 0) @(negedge clk);
      chk("R5 full valid", beat_valid, 1);
      chk("R5 full col", beat_col, 8'(8'hFE + k));
      chk("R5 full no done", burst_done, 0);
    end
    stop_en = 1'b1;
    @(negedge clk); stop_en = 1'b0;
    chk("R6 stop full page", beat_valid, 0);

    // R6 stop mid fixed burst
    set_mode(12'h003);
    start_cmd(8'h40, 2'd1, 1'b0);
    @(negedge clk); @(negedge clk);
    chk("R6 beat2 before stop", beat_col, 8'h42);
    stop_en = 1'b1;
    @(negedge clk); stop_en = 1'b0;
    chk("R6 stopped valid", beat_valid, 0);
    chk("R6 stopped done", burst_done, 0);
    @(negedge clk);
    chk("R6 still idle", beat_valid, 0);

    // R7 restart mid burst
    start_cmd(8'h10, 2'd0, 1'b0);
    @(negedge clk);
    chk("R7 beat1 first", beat_col, 8'h11);
    run_burst("R7 restart", 8'h35, 2'd2, 1'b0, 8, 3'b011, 1'b0);

    // R8 single-beat writes
    set_mode(12'h202);
    run_burst("R8 write single", 8'h21, 2'd1, 1'b1, 1, 3'b010, 1'b0);
    run_burst("R8 read bursts", 8'h21, 2'd1, 1'b0, 4, 3'b010, 1'b0);
    set_mode(12'h002);
    run_burst("R8 write bursts when off", 8'h22, 2'd0, 1'b1, 4, 3'b010, 1'b0);

    // R9 mode command refused during burst
    set_mode(12'h003);
    start_cmd(8'h80, 2'd0, 1'b0);
    mrs_en = 1'b1; mrs_op = 12'h000;
    @(negedge clk); mrs_en = 1'b0;
    repeat (8) @(negedge clk);
    run_burst("R9 mode kept len8", 8'h90, 2'd3, 1'b0, 8, 3'b011, 1'b0);

    // R11 reserved length code
    set_mode(12'h001);
    set_mode(12'h005);
    run_burst("R11 reserved ignored", 8'hA3, 2'd1, 1'b0, 2, 3'b001, 1'b0);

    // R10 lockout after mode command
    @(negedge clk); mrs_en = 1'b1; mrs_op = 12'h002;
    @(negedge clk); mrs_en = 1'b0; col_en = 1'b1; col_addr = 8'h55;
    @(negedge clk);
    chk("R10 lockout clock 1", beat_valid, 0);
    @(negedge clk); col_en = 1'b0;
    chk("R10 lockout clock 2", beat_valid, 0);
    run_burst("R10 after lockout", 8'h56, 2'd2, 1'b0, 4, 3'b010, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule